// File: doc/BRIEF.md
# Checked Dual-Port RAM

This block is a single-clock RAM with one write port and one read port. It also watches for misuse and reports it in hardware. Every read and every write is checked against three rules:

- no read may target the word being written in the same cycle;
- no access may reach at or beyond the configured logical depth, which can be smaller than the address width allows;
- no read may return a word that has never been written since reset.

A broken rule raises a dedicated flag. It also replaces the read word with a parameterised poison pattern, so a bad value cannot pass downstream as good data.

Read results are registered, with one cycle of latency. The three flags travel with the data in the same cycle. A `rd_valid` strobe marks a clean word. One written bit per word records which words hold data. A `rd_hiz` output reports when the read port would be floating, so logic that cannot use real tristates still sees that state. In simulation, each violation also prints a warning line.

Top module: `chk_dpram`

## Requirements
- R1: A write with `chip_en` and `wr_en` high stores `wr_data` at `wr_addr`. A later clean read of that address returns the word on `rd_data` one clock after the read cycle, with `rd_valid` high and no flag set.
- R2: A read and a write to the same address in one enabled cycle set `err_collide` on the next clock, with `rd_data` equal to POISON and `rd_valid` low. The write itself still takes effect.
- R3: A read at an address at or above DEPTH sets `err_range` on the next clock, with `rd_data` equal to POISON and `rd_valid` low. Address DEPTH-1 reads normally.
- R4: A write at an address at or above DEPTH is dropped. It sets `err_range` on the next clock and changes no stored word and no written bit.
- R5: A read of an in-range word that has not been written since reset sets `err_uninit` on the next clock, with `rd_data` equal to POISON and `rd_valid` low.
- R6: Synchronous active-low reset clears every written bit, all flags, `rd_valid` and `rd_data` (to zero).
- R7: The flags and `rd_valid` last one cycle. After a cycle with no enabled access, all of them are low.
- R8: While `chip_en` is low, `rd_en` and `wr_en` are ignored: nothing is stored and no read result is produced.
- R9: `rd_hiz` is high in the same cycle whenever `chip_en` or `out_en` is low. While `rd_hiz` is high, `rd_valid` is forced low.
- R10: `rd_data` keeps its last value across cycles with no enabled read.
- R11: POISON defaults to all ones. The flags are independent, so one access may raise more than one flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Enables both ports |
| out_en | input | 1 | Read output enable |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data, or POISON on a violation |
| rd_valid | output | 1 | Read data is clean and the port is driven |
| rd_hiz | output | 1 | Read port would be floating |
| err_collide | output | 1 | Same-address read and write occurred last cycle |
| err_range | output | 1 | Access beyond DEPTH occurred last cycle |
| err_uninit | output | 1 | Read of a never-written word occurred last cycle |

## Verification
A written bit that is wrongly set or cleared shows up on the first read of that word. It appears one clock later as a missing or spurious `err_uninit`, together with poison or real data on `rd_data`. A store that takes an out-of-range or disabled write shows up as corrupted data on a later read of the same word. A wrong collision or range decode shows up on the very next clock as a flag that disagrees with the cycle-accurate model in the bench.

// File: rtl/chk_dpram_pkg.sv
// Package: shared types for the checked dual-port RAM.
// Assumes nothing beyond a single clock domain.
package chk_dpram_pkg;

    // One bit per kind of misuse detected in a cycle.
    typedef struct packed {
        logic collide;
        logic range;
        logic uninit;
    } viol_t;

endpackage

// File: rtl/chk_dpram_check.sv
// Module: chk_dpram_check
// Decodes the current cycle's requests into legal actions and violations.
// Assumes rd_written is the written bit of rd_addr as it was before this
// cycle's write, and that DEPTH <= 2**ADDR_W.
module chk_dpram_check
    import chk_dpram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 48
) (
    input  logic              chip_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_written,
    output logic              wr_ok,
    output logic              rd_fire,
    output viol_t             viol,
    output logic              any_viol
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    logic wr_fire;
    logic rd_in;
    logic wr_in;

    // Range test and enable qualification for both ports.
    always_comb begin
        rd_in   = {1'b0, rd_addr} < LIMIT;
        wr_in   = {1'b0, wr_addr} < LIMIT;
        rd_fire = chip_en & rd_en;
        wr_fire = chip_en & wr_en;
        wr_ok   = wr_fire & wr_in;
    end

    // Classification of the cycle's misuse.
    always_comb begin
        viol.collide = rd_fire & wr_fire & (rd_addr == wr_addr);
        viol.range   = (rd_fire & ~rd_in) | (wr_fire & ~wr_in);
        viol.uninit  = rd_fire & rd_in & ~rd_written;
        any_viol     = viol.collide | viol.range | viol.uninit;
    end

endmodule

// File: rtl/chk_dpram_store.sv
// Module: chk_dpram_store
// Word storage plus one written bit per word.
// Assumes wr_ok is only high for in-range addresses; data words carry no
// reset, and only the written bits are cleared.
module chk_dpram_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_written
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  written_q;
    logic              rd_in;

    // Word array write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wr_addr] <= wr_data;
    end

    // Written bits: clear on reset, set on the first write to each word.
    always_ff @(posedge clk) begin
        if (!rst_n)     written_q <= '0;
        else if (wr_ok) written_q[wr_addr] <= 1'b1;
    end

    // Guarded lookup so that out-of-range addresses never index the array.
    always_comb begin
        rd_in      = {1'b0, rd_addr} < LIMIT;
        rd_word    = rd_in ? mem_q[rd_addr] : '0;
        rd_written = rd_in ? written_q[rd_addr] : 1'b0;
    end

    // R4/R8: a cycle with no legal write leaves every written bit alone.
    assert_drop_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(written_q));

endmodule

// File: rtl/chk_dpram.sv
// Module: chk_dpram (top)
// Checked RAM: one write port and one read port on a shared clock. Misuse
// is flagged, and the read word is replaced by POISON whenever it occurs.
// Assumes synchronous active-low reset and DEPTH <= 2**ADDR_W.
module chk_dpram
    import chk_dpram_pkg::*;
#(
    parameter int                 DATA_W = 16,
    parameter int                 ADDR_W = 6,
    parameter int                 DEPTH  = 48,
    parameter logic [DATA_W-1:0]  POISON = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_hiz,
    output logic              err_collide,
    output logic              err_range,
    output logic              err_uninit
);
    logic [DATA_W-1:0] rd_word;
    logic              rd_written;
    logic              wr_ok;
    logic              rd_fire;
    logic              any_viol;
    viol_t             viol;
    viol_t             viol_q;
    logic [DATA_W-1:0] data_q;
    logic              good_q;

    chk_dpram_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .rd_written (rd_written)
    );

    chk_dpram_check #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_check (
        .chip_en    (chip_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_written (rd_written),
        .wr_ok      (wr_ok),
        .rd_fire    (rd_fire),
        .viol       (viol),
        .any_viol   (any_viol)
    );

    // Output register: data, clean strobe and one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            good_q <= 1'b0;
            viol_q <= '0;
        end else begin
            viol_q <= viol;
            good_q <= rd_fire & ~any_viol;
            if (rd_fire) data_q <= any_viol ? POISON : rd_word;
            if (any_viol)
                $display("WARN chk_dpram %0t: collide=%0b range=%0b uninit=%0b wa=%0d ra=%0d",
                         $time, viol.collide, viol.range, viol.uninit, wr_addr, rd_addr);
        end
    end

    // Port drive: the floating state is reported, never produced.
    always_comb begin
        rd_hiz      = ~chip_en | ~out_en;
        rd_data     = data_q;
        rd_valid    = good_q & ~rd_hiz;
        err_collide = viol_q.collide;
        err_range   = viol_q.range;
        err_uninit  = viol_q.uninit;
    end

    // R2: a same-address read and write poison the next read result.
    assert_collide_poison_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rd_en && wr_en && rd_addr == wr_addr) |=> (err_collide && rd_data == POISON));

    // R3: an out-of-range read is flagged and poisoned.
    assert_range_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rd_en && {1'b0, rd_addr} >= DEPTH[ADDR_W:0]) |=> (err_range && rd_data == POISON));

    // R5: a read of an unwritten in-range word is flagged.
    assert_uninit_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && {1'b0, rd_addr} < DEPTH[ADDR_W:0] && !rd_written) |=> err_uninit);

    // R1: a clean strobe never comes with a flag.
    assert_clean_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !(err_collide || err_range || err_uninit));

    // R7: flags follow only a cycle with an enabled access.
    assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_en && (rd_en || wr_en)) |=> !(err_collide || err_range || err_uninit));

endmodule

// File: tb/chk_dpram_tb.sv
module chk_dpram_tb;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int DP = 48;
    localparam logic [DW-1:0] PZ = '1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en, out_en, wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_hiz, err_collide, err_range, err_uninit;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state.
    logic [DW-1:0] m_mem [64];
    bit            m_wr  [64];
    logic [DW-1:0] m_data;

    chk_dpram #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DP), .POISON(PZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_hiz(rd_hiz), .err_collide(err_collide),
        .err_range(err_range), .err_uninit(err_uninit)
    );

    always #4 clk = ~clk;

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 64; i++) m_wr[i] = 1'b0;
        m_data = '0;
    endtask

    // One clock of stimulus; checks rd_hiz at once and registered outputs after the edge.
    task automatic step(input string tag, input bit ce, input bit oe,
                        input bit we, input int wa, input logic [DW-1:0] wd,
                        input bit re, input int ra);
        bit fr, fw, col, rng, uni, hz, ev;
        chip_en = ce; out_en = oe; wr_en = we; rd_en = re;
        wr_addr = wa[AW-1:0]; wr_data = wd; rd_addr = ra[AW-1:0];
        hz  = !ce || !oe;
        fr  = ce && re;
        fw  = ce && we;
        col = fr && fw && (ra == wa);
        rng = (fr && ra >= DP) || (fw && wa >= DP);
        uni = fr && ra < DP && !m_wr[ra];
        ev  = 1'b0;
        if (fr) begin
            ev     = !(col || rng || uni);
            m_data = ev ? m_mem[ra] : PZ;
        end
        if (fw && wa < DP) begin
            m_mem[wa] = wd;
            m_wr[wa]  = 1'b1;
        end
        #1;
        cmp(tag, "rd_hiz", {31'd0, rd_hiz}, {31'd0, hz});
        @(posedge clk); #2;
        cmp(tag, "rd_data", {16'd0, rd_data}, {16'd0, m_data});
        cmp(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, ev && !hz});
        cmp(tag, "err_collide", {31'd0, err_collide}, {31'd0, col});
        cmp(tag, "err_range", {31'd0, err_range}, {31'd0, rng});
        cmp(tag, "err_uninit", {31'd0, err_uninit}, {31'd0, uni});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; chip_en = 0; out_en = 1; wr_en = 0; rd_en = 0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        // R6: reset state at the ports.
        cmp("R6", "rd_data", {16'd0, rd_data}, 32'd0);
        cmp("R6", "rd_valid", {31'd0, rd_valid}, 32'd0);
        cmp("R6", "flags", {29'd0, err_collide, err_range, err_uninit}, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        step("R1", 1, 1, 1, 5, 16'h1234, 0, 0);
        step("R1", 1, 1, 0, 0, 0, 1, 5);
        step("R5", 1, 1, 0, 0, 0, 1, 7);
        step("R11", 1, 1, 0, 0, 0, 1, 8);
        step("R2", 1, 1, 1, 9, 16'hBEEF, 1, 9);
        step("R2", 1, 1, 0, 0, 0, 1, 9);
        step("R3", 1, 1, 0, 0, 0, 1, 50);
        step("R3", 1, 1, 1, 47, 16'h0047, 0, 0);
        step("R3", 1, 1, 0, 0, 0, 1, 47);
        step("R4", 1, 1, 1, 63, 16'hDEAD, 0, 0);
        step("R4", 1, 1, 1, 48, 16'hDEAD, 1, 5);
        step("R4", 1, 1, 0, 0, 0, 1, 47);
        step("R11", 1, 1, 1, 60, 16'h0001, 1, 60);
        step("R7", 1, 1, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 0, 0, 0);
        step("R8", 0, 1, 1, 10, 16'h5555, 1, 5);
        step("R8", 1, 1, 0, 0, 0, 1, 10);
        step("R9", 1, 0, 0, 0, 0, 1, 5);
        step("R9", 1, 1, 0, 0, 0, 1, 5);
        do_reset();
        step("R6", 1, 1, 0, 0, 0, 1, 5);
        for (int i = 0; i < 400; i++) begin
            step("R1", ($urandom % 8) != 0, ($urandom % 6) != 0,
                 $urandom % 2, $urandom % 64, DW'($urandom),
                 $urandom % 2, $urandom % 64);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule